// File: doc/BRIEF.md
# Multiplexed BCD Digit Scanner

The block holds a five-digit BCD result and an overrange flag, and sends them out one digit at a time. The digit-select lines are one-hot and active high. A 4-bit BCD bus is shared by all digits, and an active-low strobe marks each digit for capture. The conversion controller pulses `load_i` when it has a new result. That pulse latches the result and starts a scan series, which begins at the most significant digit.

The scan after a load is the strobed scan. In that scan the strobe pulses low for half a clock once in every digit slot, so a processor or an external latch can take all five digits. The scanner then keeps cycling through the digits with no strobes, so a multiplexed display stays refreshed.

When the latched result is overrange, the BCD bus reads zero. The digit lines go low after the point in the D1 slot where the last strobe falls. They stay low until the controller signals the start of reference integration with `ref_start_i`. Scanning then runs again. The repeated on/off pattern makes the display blink.

Top module: `bcd_digit_scanner`

## Requirements
- R1: While `rst_n` is low, and after release until the first load, `dig_sel_o` is all zero, `bcd_o` is zero and `strobe_n_o` is high.
- R2: After a cycle with `load_i` high, the next cycle selects the most significant digit: `dig_sel_o` bit 4 high and all other bits low. Bit k of `dig_sel_o` selects digit k, which is carried on `digits_i[4k+3:4k]`. Digit 0 is the least significant. At most one select bit is ever high.
- R3: The strobed scan runs from bit 4 down to bit 0. Its first slot lasts 201 clocks and each of the other four lasts 200 clocks.
- R4: While a digit is selected and the result is not overrange, `bcd_o` equals that digit's latched value. It changes in the same cycle as `dig_sel_o`. With no digit selected, `bcd_o` is zero.
- R5: `strobe_n_o` is low only during the second (low) half of one clock cycle in each strobed slot. That cycle is at offset 101 in the first slot and at offset 100 in the others, where offset 0 is the first cycle of a slot.
- R6: Each load produces exactly five strobe pulses. No strobe appears on any later scan.
- R7: For a result in range, scanning continues without end after the strobed scan. Every later slot, including each later bit-4 slot, lasts 200 clocks.
- R8: For an overrange result, `bcd_o` is zero for the whole time the result is shown.
- R9: For an overrange result, every scan drops all digit lines in the cycle after offset 100 of the bit-0 slot. The lines stay low until the cycle after `ref_start_i` is seen high. Scanning then restarts at bit 4 with 200-clock slots and no strobe.
- R10: `ref_start_i` has no effect while the digit lines are not blanked.
- R11: A load in the middle of a scan abandons it and starts a new strobed scan of the new result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the strobe uses its falling edge as well |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | One-cycle pulse: latch a new result and start a strobed scan |
| ovr_i | input | 1 | Overrange flag, latched with the result |
| ref_start_i | input | 1 | Start of reference integration; ends blanking |
| digits_i | input | 20 | Five BCD digits; digit k on bits 4k+3..4k |
| dig_sel_o | output | 5 | One-hot positive digit select; bit 4 is the most significant digit |
| bcd_o | output | 4 | BCD value of the selected digit |
| strobe_n_o | output | 1 | Active-low half-clock capture strobe |

## Verification
A slot counter that is off by one moves every later digit boundary and every later strobe by one cycle. That error shows at the first boundary of the affected slot, 200 clocks after the load at the latest. A wrong strobed-scan flag gives either a sixth strobe at offset 100 of the next bit-4 slot, or too few strobes within the first 1001 cycles. A blanking state that is not left, or not entered, shows within one cycle of the D1 strobe point or of the `ref_start_i` pulse. A wrong overrange latch shows straight away as non-zero BCD data in the first slot.

// File: rtl/digit_scan_pkg.sv
`timescale 1ns/1ps
package digit_scan_pkg;
    typedef enum logic [1:0] {
        SCAN_IDLE  = 2'd0,
        SCAN_RUN   = 2'd1,
        SCAN_BLANK = 2'd2
    } scan_mode_e;
endpackage

// File: rtl/digit_scan_ctrl.sv
`timescale 1ns/1ps
module digit_scan_ctrl
    import digit_scan_pkg::*;
#(
    parameter int NUM_DIGITS  = 5,
    parameter int DIGIT_W     = 4,
    parameter int SLOT_CLKS   = 200,
    parameter int STB_POS     = 100,
    parameter int FIRST_EXTRA = 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load_i,
    input  logic                          ovr_i,
    input  logic                          ref_start_i,
    input  logic [NUM_DIGITS*DIGIT_W-1:0] data_i,
    output logic                          active_o,
    output logic [$clog2(NUM_DIGITS)-1:0] idx_o,
    output logic                          ovr_o,
    output logic [NUM_DIGITS*DIGIT_W-1:0] data_o,
    output logic                          strobe_req_o
);
    localparam int IDX_W = $clog2(NUM_DIGITS);
    localparam int CNT_W = $clog2(SLOT_CLKS + FIRST_EXTRA + 1);
    localparam logic [IDX_W-1:0] MSD_IDX = IDX_W'(NUM_DIGITS - 1);
    localparam logic [CNT_W-1:0] LAST_N  = CNT_W'(SLOT_CLKS - 1);
    localparam logic [CNT_W-1:0] LAST_F  = CNT_W'(SLOT_CLKS + FIRST_EXTRA - 1);
    localparam logic [CNT_W-1:0] POS_N   = CNT_W'(STB_POS);
    localparam logic [CNT_W-1:0] POS_F   = CNT_W'(STB_POS + FIRST_EXTRA);

    typedef struct packed {
        scan_mode_e                    mode;
        logic [IDX_W-1:0]              idx;
        logic [CNT_W-1:0]              cnt;
        logic                          first;
        logic                          strobing;
        logic                          ovr;
        logic                          req;
        logic [NUM_DIGITS*DIGIT_W-1:0] data;
    } scan_st_t;

    scan_st_t         st_d, st_q;
    logic [CNT_W-1:0] last_cnt;
    logic [CNT_W-1:0] pos_next;

    always_comb begin
        st_d     = st_q;
        last_cnt = st_q.first ? LAST_F : LAST_N;
        if (load_i) begin
            st_d.mode     = SCAN_RUN;
            st_d.idx      = MSD_IDX;
            st_d.cnt      = '0;
            st_d.first    = 1'b1;
            st_d.strobing = 1'b1;
            st_d.ovr      = ovr_i;
            st_d.data     = data_i;
        end else begin
            unique case (st_q.mode)
                SCAN_RUN: begin
                    if (st_q.ovr && st_q.idx == '0 && st_q.cnt == POS_N) begin
                        // overrange: blank right after the last strobe point
                        st_d.mode     = SCAN_BLANK;
                        st_d.strobing = 1'b0;
                        st_d.cnt      = '0;
                    end else if (st_q.cnt == last_cnt) begin
                        st_d.cnt   = '0;
                        st_d.first = 1'b0;
                        if (st_q.idx == '0) begin
                            st_d.idx      = MSD_IDX;
                            st_d.strobing = 1'b0;
                        end else begin
                            st_d.idx = st_q.idx - IDX_W'(1);
                        end
                    end else begin
                        st_d.cnt = st_q.cnt + CNT_W'(1);
                    end
                end
                SCAN_BLANK: begin
                    if (ref_start_i) begin
                        st_d.mode  = SCAN_RUN;
                        st_d.idx   = MSD_IDX;
                        st_d.cnt   = '0;
                        st_d.first = 1'b0;
                    end
                end
                default: ;
            endcase
        end
        pos_next = st_d.first ? POS_F : POS_N;
        st_d.req = (st_d.mode == SCAN_RUN) && st_d.strobing && (st_d.cnt == pos_next);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: SCAN_IDLE, idx: '0, cnt: '0, first: 1'b0, strobing: 1'b0,
                      ovr: 1'b0, req: 1'b0, data: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o     = (st_q.mode == SCAN_RUN);
    assign idx_o        = st_q.idx;
    assign ovr_o        = st_q.ovr;
    assign data_o       = st_q.data;
    assign strobe_req_o = st_q.req;
endmodule

// File: rtl/digit_scan_outmux.sv
`timescale 1ns/1ps
module digit_scan_outmux #(
    parameter int NUM_DIGITS = 5,
    parameter int DIGIT_W    = 4
) (
    input  logic                          active_i,
    input  logic [$clog2(NUM_DIGITS)-1:0] idx_i,
    input  logic                          ovr_i,
    input  logic [NUM_DIGITS*DIGIT_W-1:0] data_i,
    output logic [NUM_DIGITS-1:0]         dig_sel_o,
    output logic [DIGIT_W-1:0]            bcd_o
);
    localparam int IDX_W = $clog2(NUM_DIGITS);

    logic [NUM_DIGITS-1:0] sel_vec;

    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_sel
        assign sel_vec[g] = active_i && (idx_i == IDX_W'(g));
    end

    always_comb begin
        bcd_o = '0;
        for (int k = 0; k < NUM_DIGITS; k++) begin
            if (sel_vec[k]) begin
                bcd_o = bcd_o | data_i[k*DIGIT_W +: DIGIT_W];
            end
        end
        if (ovr_i) begin
            bcd_o = '0;
        end
    end

    assign dig_sel_o = sel_vec;
endmodule

// File: rtl/digit_scan_strobe.sv
`timescale 1ns/1ps
module digit_scan_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    output logic strobe_n_o
);
    logic fall_q;
    logic rise_q;

    // set on the falling edge inside the requesting cycle
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) fall_q <= 1'b0;
        else        fall_q <= req_i;
    end

    // the next rising edge ends the pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rise_q <= 1'b0;
        else        rise_q <= fall_q;
    end

    assign strobe_n_o = ~(fall_q & ~rise_q);
endmodule

// File: rtl/bcd_digit_scanner.sv
`timescale 1ns/1ps
module bcd_digit_scanner #(
    parameter int NUM_DIGITS  = 5,
    parameter int DIGIT_W     = 4,
    parameter int SLOT_CLKS   = 200,
    parameter int STB_POS     = 100,
    parameter int FIRST_EXTRA = 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load_i,
    input  logic                          ovr_i,
    input  logic                          ref_start_i,
    input  logic [NUM_DIGITS*DIGIT_W-1:0] digits_i,
    output logic [NUM_DIGITS-1:0]         dig_sel_o,
    output logic [DIGIT_W-1:0]            bcd_o,
    output logic                          strobe_n_o
);
    localparam int IDX_W = $clog2(NUM_DIGITS);

    logic                          active;
    logic [IDX_W-1:0]              idx;
    logic                          ovr_lat;
    logic [NUM_DIGITS*DIGIT_W-1:0] data_lat;
    logic                          strobe_req;

    digit_scan_ctrl #(
        .NUM_DIGITS(NUM_DIGITS), .DIGIT_W(DIGIT_W), .SLOT_CLKS(SLOT_CLKS),
        .STB_POS(STB_POS), .FIRST_EXTRA(FIRST_EXTRA)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .ovr_i(ovr_i),
        .ref_start_i(ref_start_i), .data_i(digits_i), .active_o(active),
        .idx_o(idx), .ovr_o(ovr_lat), .data_o(data_lat), .strobe_req_o(strobe_req)
    );

    digit_scan_outmux #(.NUM_DIGITS(NUM_DIGITS), .DIGIT_W(DIGIT_W)) u_mux (
        .active_i(active), .idx_i(idx), .ovr_i(ovr_lat), .data_i(data_lat),
        .dig_sel_o(dig_sel_o), .bcd_o(bcd_o)
    );

    digit_scan_strobe u_stb (
        .clk(clk), .rst_n(rst_n), .req_i(strobe_req), .strobe_n_o(strobe_n_o)
    );
endmodule

// File: rtl/digit_scan_chk.sv
`timescale 1ns/1ps
module digit_scan_chk #(
    parameter int NUM_DIGITS = 5,
    parameter int DIGIT_W    = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  load,
    input logic [NUM_DIGITS-1:0] dig_sel,
    input logic [DIGIT_W-1:0]    bcd,
    input logic                  strobe_n
);
    localparam logic [NUM_DIGITS-1:0] MSD_HOT = {1'b1, {(NUM_DIGITS-1){1'b0}}};
    localparam logic [NUM_DIGITS-1:0] LSD_HOT = NUM_DIGITS'(1);

    // R2
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dig_sel));

    // R2
    load_msd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (dig_sel == MSD_HOT));

    // R4
    blank_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dig_sel == '0) |-> (bcd == '0));

    // R5
    strobe_in_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_n |-> (dig_sel != '0));

    // R3
    scan_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && dig_sel != '0) |=>
            (dig_sel == $past(dig_sel) || dig_sel == ($past(dig_sel) >> 1) ||
             dig_sel == '0 || (dig_sel == MSD_HOT && $past(dig_sel) == LSD_HOT)));
endmodule

bind bcd_digit_scanner digit_scan_chk #(.NUM_DIGITS(NUM_DIGITS), .DIGIT_W(DIGIT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .load(load_i), .dig_sel(dig_sel_o),
    .bcd(bcd_o), .strobe_n(strobe_n_o)
);

// File: tb/sim_bcd_digit_scanner.sv
`timescale 1ns/1ps
module sim_bcd_digit_scanner;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_i = 1'b0;
    logic        ovr_i = 1'b0;
    logic        ref_start_i = 1'b0;
    logic [19:0] digits_i = '0;
    logic [4:0]  dig_sel_o;
    logic [3:0]  bcd_o;
    logic        strobe_n_o;

    int checks = 0;
    int errors = 0;
    logic [3:0] dat [5];

    always #2.5 clk = ~clk;

    bcd_digit_scanner u0 (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .ovr_i(ovr_i),
        .ref_start_i(ref_start_i), .digits_i(digits_i), .dig_sel_o(dig_sel_o),
        .bcd_o(bcd_o), .strobe_n_o(strobe_n_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // expected selected digit index, -1 when blank; kind 1 = overrange
    function automatic int exp_idx(input int kind, input int t, input int r);
        int rel;
        if (kind == 1 && t > 901) begin
            if (t <= r) return -1;
            rel = t - r - 1;
            if (rel <= 900) return 4 - rel / 200;
            return -1;
        end
        if (t <= 200)  return 4;
        if (t <= 1000) return 3 - (t - 201) / 200;
        return 4 - ((t - 1001) % 1000) / 200;
    endfunction

    task automatic do_load(input logic [3:0] d4, input logic [3:0] d3, input logic [3:0] d2,
                           input logic [3:0] d1, input logic [3:0] d0, input logic ovr);
        dat[4] = d4; dat[3] = d3; dat[2] = d2; dat[1] = d1; dat[0] = d0;
        digits_i = {d4, d3, d2, d1, d0};
        ovr_i    = ovr;
        load_i   = 1'b1;
        @(posedge clk); #1;
        load_i   = 1'b0;
    endtask

    // called 1 ns after the rising edge that starts cycle t0
    task automatic observe(input int t0, input int n, input int kind, input int r,
                           input string dtag, input string btag, input int exp_stb);
        int e_dig = 0, e_bcd = 0, e_stb = 0, nstb = 0;
        int a_dig = 0, x_dig = 0, a_bcd = 0, x_bcd = 0, t_stb = 0;
        for (int t = t0; t < t0 + n; t++) begin
            int   ei;
            logic [4:0] es;
            logic [3:0] eb;
            bit   sx;
            ei = exp_idx(kind, t, r);
            es = (ei < 0) ? 5'd0 : 5'(1 << ei);
            eb = (ei < 0 || kind == 1) ? 4'd0 : dat[ei];
            if (dig_sel_o !== es) begin
                if (e_dig == 0) begin a_dig = int'(dig_sel_o); x_dig = int'(es); end
                e_dig++;
            end
            if (bcd_o !== eb) begin
                if (e_bcd == 0) begin a_bcd = int'(bcd_o); x_bcd = int'(eb); end
                e_bcd++;
            end
            if (t == r) ref_start_i = 1'b1;
            @(negedge clk); #1;
            sx = (t <= 901) && (t >= 101) && ((t - 101) % 200 == 0);
            if (!strobe_n_o) nstb++;
            if (strobe_n_o !== !sx) begin
                if (e_stb == 0) t_stb = t;
                e_stb++;
            end
            @(posedge clk); #1;
            ref_start_i = 1'b0;
        end
        chk(e_dig == 0, dtag, a_dig, x_dig);
        chk(e_bcd == 0, btag, a_bcd, x_bcd);
        chk(e_stb == 0, "R5 strobe placement, first bad cycle", t_stb, -1);
        chk(nstb == exp_stb, "R6 strobe count", nstb, exp_stb);
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        #1;
        chk(dig_sel_o == 5'd0, "R1 dig_sel in reset", int'(dig_sel_o), 0);
        chk(bcd_o == 4'd0, "R1 bcd in reset", int'(bcd_o), 0);
        chk(strobe_n_o == 1'b1, "R1 strobe in reset", int'(strobe_n_o), 1);
        rst_n = 1'b1;
        repeat (5) @(posedge clk);
        @(negedge clk); #1;
        chk(dig_sel_o == 5'd0 && bcd_o == 4'd0, "R1 idle after reset", int'(dig_sel_o), 0);
        chk(strobe_n_o == 1'b1, "R1 strobe idle", int'(strobe_n_o), 1);
        @(posedge clk); #1;
    endtask

    task automatic t_normal();
        do_load(4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 1'b0);
        chk(dig_sel_o == 5'b10000, "R2 first digit selected", int'(dig_sel_o), 16);
        chk(bcd_o == 4'd1, "R2 first digit data", int'(bcd_o), 1);
        observe(0, 1001, 0, -1, "R3 strobed scan digit timing", "R4 data", 5);
        observe(1001, 1000, 0, -1, "R7 refresh scan digit timing", "R4 refresh data", 0);
        observe(2001, 700, 0, 2100, "R10 ref_start ignored", "R4 data after ref_start", 0);
    endtask

    task automatic t_reload();
        do_load(4'd9, 4'd0, 4'd8, 4'd7, 4'd6, 1'b0);
        observe(0, 350, 0, -1, "R3 partial scan", "R4 partial data", 2);
        do_load(4'd3, 4'd9, 4'd1, 4'd0, 4'd2, 1'b0);
        chk(dig_sel_o == 5'b10000, "R11 restart at top digit", int'(dig_sel_o), 16);
        observe(0, 1001, 0, -1, "R11 restarted scan timing", "R11 new data", 5);
    endtask

    task automatic t_overrange();
        do_load(4'd7, 4'd7, 4'd7, 4'd7, 4'd7, 1'b1);
        observe(0, 902, 1, 1200, "R9 overrange strobed scan", "R8 overrange data", 5);
        observe(902, 1300, 1, 1200, "R9 blank and resume", "R8 overrange data later", 0);
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_normal();
        t_reload();
        t_overrange();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule